// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block lets software talk to Ethernet PHY management registers through two 32-bit words on a simple register bus. A command word placed in the gateway register, with its busy bit set, makes the block produce one complete management frame on the MDC clock and the MDIO data line. For a read, the block releases MDIO at the turnaround and shifts in the sixteen bits the PHY sends back. Those bits land in the low half of the gateway. Busy drops by itself when the frame ends, so software polls one bit and then reads the result from the same word.

The configuration register sets the timing in core-clock units. It holds the MDC half-period, the phase at which each outgoing bit is placed on MDIO, and the phase at which incoming bits are sampled. It also stores a few pad-setting bits that software can read back. Writing an all-zero word to the gateway abandons whatever frame is running.

Top module: `mdio_gw_master`

## Requirements
- R1: The gateway register sits at byte address 0x0 and the configuration register at 0x4. `rd_data` shows the word at `addr` from the cycle after any write to it, and any other address reads as zero. After reset the gateway reads 0 and the configuration reads 0x0D065515: launch phase 13 in [31:24], sample phase 6 in [23:16], period value 85 in [15:8], and pad bits [7:0] = 0x15.
- R2: A gateway write while idle whose bit 30 is 1 starts a frame, and bit 30 then reads 1. The block clears bit 30 itself after exactly 64·2·(P+1) clock edges, where P is configuration bits [15:8].
- R3: During a frame, MDC repeats with a period of 2·(P+1) clocks. In each period it is low for the first P+1 clocks and high for the rest. The first period begins in the cycle after the launching write. MDC is low whenever no frame is running.
- R4: The 64 frame bits are sent in this order: 32 ones, 0, gateway bit 28, opcode [27:26], PHY address [25:21], register address [20:16], two turnaround bits, then 16 data bits. Each field goes MSB first. A non-read frame drives turnaround 1,0 and then gateway [15:0].
- R5: Bit k of the frame appears on `mdio_o` starting one clock after phase L of MDC period k, where L = min(configuration [31:24], 2P+1).
- R6: Opcode value 2 marks a read. On a read, `mdio_oe` falls at the launch of bit 46 (the first turnaround bit) and stays low to the end of the frame, with `mdio_o` reading 1. Every other opcode drives all 64 bits.
- R7: On a read, `mdio_i` is sampled at phase S = min(configuration [23:16], 2P+1) of MDC periods 48 to 63, first bit as MSB. When busy clears, gateway [15:0] holds the 16 sampled bits and gateway [31:16] is unchanged apart from bit 30.
- R8: A non-zero gateway write while a frame runs is ignored. The frame goes on, and the gateway contents are unchanged.
- R9: Writing all zeros to the gateway clears it and stops the frame. From the next cycle the gateway reads 0 and MDC and `mdio_oe` are low.
- R10: Between frames `mdio_oe` is low and `mdio_o` is high.
- R11: A gateway write while idle with bit 30 at 0 stores the word as it is and starts no MDC activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high when the master drives |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A register write shows on `rd_data` one edge after it is taken. MDC follows the phase count in the same cycle, so its edges fall exactly on multiples of P+1 clocks from the launch. `mdio_o` and `mdio_oe` change one edge after the launch phase. Busy and the captured read data change together, 64·2·(P+1) edges after the launching write. The bench advances a behavioural frame model on each rising edge and compares every output two time units later, while inputs move only on falling edges. Frame lengths are confirmed by counting the cycles during which bit 30 reads 1.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int CNT_W      = 9;

  localparam int BUSY_BIT   = 30;
  localparam logic [1:0] OP_READ = 2'd2;

  // last phase of one MDC period: 2*(p+1)-1
  function automatic logic [CNT_W-1:0] period_last(logic [7:0] p);
    return {p, 1'b1};
  endfunction

  // a phase point beyond the period end collapses onto the last phase
  function automatic logic [CNT_W-1:0] clamp_point(logic [7:0] pt, logic [CNT_W-1:0] last);
    return ({1'b0, pt} > last) ? last : {1'b0, pt};
  endfunction

  function automatic logic gw_is_read(logic [31:0] gw);
    return gw[27:26] == OP_READ;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(logic [31:0] gw);
    logic rd;
    rd = gw_is_read(gw);
    return {32'hFFFF_FFFF, 1'b0, gw[28], gw[27:26], gw[25:21], gw[20:16],
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : gw[15:0])};
  endfunction

  function automatic logic [31:0] cfg_pack(logic [7:0] out_pt, logic [7:0] in_pt,
                                           logic [7:0] period, logic [7:0] pads);
    return {out_pt, in_pt, period, pads};
  endfunction

endpackage

// File: rtl/mdio_gw_regs.sv
module mdio_gw_regs
  import mdio_gw_pkg::*;
#(
  parameter int          ADDR_W  = 3,
  parameter int          GW_OFF  = 0,
  parameter int          CFG_OFF = 4,
  parameter logic [31:0] CFG_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  input  logic              frame_done,
  input  logic [15:0]       rd_word,
  output logic [31:0]       gw_q,
  output logic [31:0]       cfg_q,
  output logic [31:0]       rd_data,
  output logic              busy,
  output logic              gw_sel,
  output logic              abort
);

  localparam logic [ADDR_W-1:0] GW_A  = ADDR_W'(GW_OFF);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFF);

  assign gw_sel = wr_en && (addr == GW_A);
  assign abort  = gw_sel && (wr_data == 32'h0);
  assign busy   = gw_q[BUSY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gw_q  <= '0;
      cfg_q <= CFG_RST;
    end else begin
      if (abort) begin
        gw_q <= '0;
      end else if (frame_done) begin
        gw_q[BUSY_BIT] <= 1'b0;
        if (gw_is_read(gw_q)) gw_q[15:0] <= rd_word;
      end else if (gw_sel && !busy) begin
        gw_q <= wr_data;
      end
      if (wr_en && (addr == CFG_A)) cfg_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == GW_A)  rd_data = gw_q;
    if (addr == CFG_A) rd_data = cfg_q;
  end

endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_gw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [31:0] cfg_q,
  output logic        mdc,
  output logic        launch_stb,
  output logic        sample_stb,
  output logic        bit_end
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [7:0]       half_m1;

  assign half_m1    = cfg_q[15:8];
  assign last       = period_last(half_m1);
  assign bit_end    = run && (cnt >= last);
  assign launch_stb = run && (cnt == clamp_point(cfg_q[31:24], last));
  assign sample_stb = run && (cnt == clamp_point(cfg_q[23:16], last));
  assign mdc        = run && (cnt > {1'b0, half_m1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || bit_end)   cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_gw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             launch_stb,
  input  logic             sample_stb,
  input  logic             bit_end,
  input  logic [31:0]      gw_q,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_done,
  output logic             frame_is_read,
  output logic [15:0]      rd_word
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_I     = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_I   = IDX_W'(DATA_IDX);

  logic [FRAME_BITS-1:0] frame;
  logic                  o_q, oe_q;
  logic [15:0]           cap_q;
  logic                  take;

  assign frame         = build_frame(gw_q);
  assign frame_is_read = gw_is_read(gw_q);
  assign frame_done    = run && bit_end && (bit_idx == LAST_IDX);
  assign take          = sample_stb && (bit_idx >= DATA_I);
  // bypass so a sample on the final phase still reaches the register
  assign rd_word       = take ? {cap_q[14:0], mdio_i} : cap_q;
  assign mdio_o        = run ? o_q : 1'b1;
  assign mdio_oe       = run && oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
      cap_q   <= '0;
    end else if (!run) begin
      bit_idx <= '0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      if (bit_end) bit_idx <= bit_idx + 1'b1;
      if (take)    cap_q   <= {cap_q[14:0], mdio_i};
      if (frame_done) begin
        oe_q <= 1'b0;
      end else if (launch_stb) begin
        o_q  <= frame[LAST_IDX - bit_idx];
        oe_q <= !(frame_is_read && (bit_idx >= TA_I));
      end
    end
  end

endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master
  import mdio_gw_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int GW_OFFSET  = 0,
  parameter int CFG_OFFSET = 4,
  parameter int RST_PERIOD = 85,
  parameter int RST_IN_PT  = 6,
  parameter int RST_OUT_PT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam logic [31:0] CFG_RST = cfg_pack(8'(RST_OUT_PT), 8'(RST_IN_PT),
                                             8'(RST_PERIOD), 8'h15);

  logic [31:0]      gw_q, cfg_q;
  logic             busy, gw_sel, abort;
  logic             launch_stb, sample_stb, bit_end;
  logic             frame_done, frame_is_read;
  logic [IDX_W-1:0] bit_idx;
  logic [15:0]      rd_word;

  mdio_gw_regs #(
    .ADDR_W(ADDR_W), .GW_OFF(GW_OFFSET), .CFG_OFF(CFG_OFFSET), .CFG_RST(CFG_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .frame_done(frame_done), .rd_word(rd_word), .gw_q(gw_q), .cfg_q(cfg_q),
    .rd_data(rd_data), .busy(busy), .gw_sel(gw_sel), .abort(abort)
  );

  mdio_clk_div u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .cfg_q(cfg_q), .mdc(mdc),
    .launch_stb(launch_stb), .sample_stb(sample_stb), .bit_end(bit_end)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(busy), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .bit_end(bit_end), .gw_q(gw_q), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .bit_idx(bit_idx),
    .frame_done(frame_done), .frame_is_read(frame_is_read), .rd_word(rd_word)
  );

endmodule

// File: rtl/mdio_gw_checker.sv
module mdio_gw_checker
  import mdio_gw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             gw_sel,
  input logic             abort,
  input logic [31:0]      gw_q,
  input logic             frame_done,
  input logic             frame_is_read,
  input logic             bit_end,
  input logic [IDX_W-1:0] bit_idx,
  input logic             mdc,
  input logic             mdio_oe
);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !abort && !frame_done |=> busy);

  p_ignore_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && gw_sel && !abort && !frame_done |=> $stable(gw_q));

  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (gw_q == 32'h0) && !mdc && !mdio_oe);

  p_mdc_low_new_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !mdc);

  p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frame_is_read && (bit_idx > IDX_W'(TA_IDX)) |-> !mdio_oe);

  p_start_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gw_sel));

endmodule

bind mdio_gw_master mdio_gw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .gw_sel(gw_sel), .abort(abort),
  .gw_q(gw_q), .frame_done(frame_done), .frame_is_read(frame_is_read),
  .bit_end(bit_end), .bit_idx(bit_idx), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_gw_master.sv
module sim_mdio_gw_master;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int vectors = 0;
  int errors  = 0;

  mdio_gw_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic        busy_m;
  logic [31:0] gw_m, cfg_m;
  logic        o_m, oe_m;
  logic [15:0] cap_m;
  logic [15:0] phy_word = 16'h0;
  int          t_m;

  function automatic logic [63:0] ref_frame(logic [31:0] w);
    logic rd;
    rd = (w[27:26] == 2'd2);
    ref_frame = {32'hFFFF_FFFF, 1'b0, w[28], w[27:26], w[25:21], w[20:16],
                 rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : w[15:0]};
  endfunction

  function automatic int per_n(logic [31:0] c);
    per_n = 2 * (int'(c[15:8]) + 1);
  endfunction

  function automatic int pt_clamp(logic [7:0] v, int n);
    pt_clamp = (int'(v) > n - 1) ? n - 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m = 1'b0; gw_m = 32'h0; cfg_m = 32'h0D06_5515;
      o_m = 1'b1; oe_m = 1'b0; cap_m = 16'h0; t_m = 0;
    end else begin
      logic bb, fin, rd;
      int n, k, ph;
      bb = busy_m; fin = 1'b0;
      rd = (gw_m[27:26] == 2'd2);
      if (!bb) begin
        o_m = 1'b1; oe_m = 1'b0; t_m = 0;
      end else begin
        n = per_n(cfg_m); k = t_m / n; ph = t_m % n;
        if (ph == pt_clamp(cfg_m[31:24], n)) begin
          o_m  = ref_frame(gw_m)[63 - k];
          oe_m = !(rd && k >= 46);
        end
        if (ph == pt_clamp(cfg_m[23:16], n) && k >= 48) cap_m = {cap_m[14:0], mdio_i};
        if (ph == n - 1 && k == 63) fin = 1'b1;
        else t_m = t_m + 1;
      end
      if (wr_en && addr == 3'd0 && wr_data == 32'h0) begin
        gw_m = 32'h0; busy_m = 1'b0;
      end else if (fin) begin
        busy_m = 1'b0; oe_m = 1'b0; gw_m[30] = 1'b0;
        if (rd) gw_m[15:0] = cap_m;
      end else if (wr_en && addr == 3'd0 && !bb) begin
        gw_m = wr_data; busy_m = wr_data[30];
      end
      if (wr_en && addr == 3'd4) cfg_m = wr_data;
    end
  end

  // PHY side: return phy_word during the data periods of a frame
  always @(negedge clk) begin
    if (busy_m && (t_m / per_n(cfg_m)) >= 48)
      mdio_i <= phy_word[63 - (t_m / per_n(cfg_m))];
    else
      mdio_i <= 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 time units after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      int n;
      n = per_n(cfg_m);
      chk("R3 mdc", {31'b0, mdc}, {31'b0, busy_m && ((t_m % n) >= n / 2)});
      chk("R6 R10 mdio_oe", {31'b0, mdio_oe}, {31'b0, busy_m && oe_m});
      chk("R4 R5 mdio_o", {31'b0, mdio_o}, {31'b0, busy_m ? o_m : 1'b1});
      chk("R1 rd_data", rd_data,
          (addr == 3'd0) ? gw_m : (addr == 3'd4) ? cfg_m : 32'h0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0; wr_data = 32'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
    @(negedge clk);
    addr = 3'd0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (rd_data[30] === 1'b1 && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] rg, input logic [15:0] d);
    cmd = 32'h5000_0000 | (32'(op) << 26) | (32'(phy) << 21) | (32'(rg) << 16) | 32'(d);
  endfunction

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values, R10 idle pins
    rd(3'd0, v); chk("R1 gateway reset", v, 32'h0);
    rd(3'd4, v); chk("R1 config reset", v, 32'h0D06_5515);
    rd(3'd2, v); chk("R1 unmapped address", v, 32'h0);
    chk("R10 idle pins", {30'b0, mdio_oe, mdio_o}, 32'h1);

    // R11 store without starting
    wr(3'd0, 32'h1234_5678);
    repeat (20) @(negedge clk);
    chk("R11 stored word", rd_data, 32'h1234_5678);
    chk("R11 no mdc", {31'b0, mdc}, 32'h0);

    // write frame, P=1, sample 3, launch 0; R8 ignored write mid-frame
    wr(3'd4, 32'h0003_0115);
    rd(3'd4, v); chk("R1 config readback", v, 32'h0003_0115);
    w = cmd(2'd1, 5'd5, 5'h1A, 16'hA5C3);
    wr(3'd0, w);
    repeat (40) @(negedge clk);
    wr(3'd0, 32'h1111_1111);
    chk("R8 busy kept", {31'b0, rd_data[30]}, 32'h1);
    wait_idle(cyc);
    chk("R8 gateway unchanged", rd_data, w & ~32'h4000_0000);

    // read frame, P=2, sample 4, launch 1
    wr(3'd4, 32'h0104_0215);
    phy_word = 16'hBEEF;
    w = cmd(2'd2, 5'h11, 5'd3, 16'h0);
    wr(3'd0, w);
    wait_idle(cyc);
    chk("R2 frame length P=2", cyc, 64 * 6);
    chk("R7 read data", rd_data, {w[31], 1'b0, w[29:16], 16'hBEEF});

    // read frame with both points clamped to the last phase
    wr(3'd4, 32'h0D0D_0215);
    phy_word = 16'h5A0F;
    w = cmd(2'd2, 5'h03, 5'h1F, 16'h0);
    wr(3'd0, w);
    wait_idle(cyc);
    chk("R5 R7 clamped read data", rd_data[15:0], 32'h5A0F);

    // R9 abort during a write frame
    wr(3'd0, cmd(2'd1, 5'd1, 5'd2, 16'hFFFF));
    repeat (100) @(negedge clk);
    wr(3'd0, 32'h0);
    chk("R9 gateway cleared", rd_data, 32'h0);
    chk("R9 pins quiet", {30'b0, mdc, mdio_oe}, 32'h0);

    // R3 R2 default timing, P=85
    wr(3'd4, 32'h0D06_5515);
    phy_word = 16'h8001;
    w = cmd(2'd2, 5'h1F, 5'd0, 16'h0);
    wr(3'd0, w);
    wait_idle(cyc);
    chk("R2 R3 frame length P=85", cyc, 64 * 172);
    chk("R7 default read data", rd_data[15:0], 32'h8001);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule